// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

The block gathers interrupt requests from a parameterized number of lines (eight by default) into a sticky pending register. A request pulse of any length is held there until that line is serviced. A software-written enable register gates which pending lines may be chosen. A fixed priority encoder picks the lowest-numbered eligible line. When the issue logic is free, the block raises a one-cycle start strobe, presents the winning line number, and clears that line's pending bit.

Two build-time options shape the acceptance rule:

- `TOP_NMI` makes line 0 ignore the enable register, so it behaves as a non-maskable source.
- `SEQ_MODE` adds a hold-off that tracks the core's in-service status bit, delayed by one cycle. While the hold-off is set, no line can start, line 0 included.

With `SEQ_MODE` off, a start can be issued while the core is already servicing a line, which lets the core preempt. Instruction execution, context stacking and flag restore belong to the core, not to this block.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A request seen on `req_i[i]` at any clock edge sets pending bit i. The bit stays set until the edge at which line i is started, so a one-cycle pulse is never lost.
- R2: Bit i of the enable register is written from `en_wdata_i[i]` when `en_we_i` is high, where 1 means allowed. A pending line whose enable bit is 0 keeps its pending bit but is never started. It starts one cycle after its enable bit is written to 1.
- R3: Among eligible pending lines, the lowest index wins. `vec_o` carries that index as a binary number, and `clr_o` is one-hot at that bit while `start_o` is high.
- R4: `start_o` is high for exactly one cycle per accepted interrupt. No further start is issued until `ack_i` has been sampled high at a later edge. The next start can come in the cycle after that edge.
- R5: If `req_i[i]` is high in the same cycle that line i is started, pending bit i remains set. Line i is started again once the acknowledge has been seen.
- R6: With `TOP_NMI` = 1, line 0 is started even while its enable bit is 0.
- R7: With `SEQ_MODE` = 1, no start is issued in the cycle after any cycle in which `active_i` is high. This applies to every line, line 0 included.
- R8: With `SEQ_MODE` = 1, once `active_i` returns low, a pending eligible line is started in the next cycle. It makes no difference whether the core cleared the bit by a return or by an explicit clear.
- R9: With `SEQ_MODE` = 0, `active_i` has no effect, and a start is issued while `active_i` is high.
- R10: An active-low reset clears every pending bit, sets all enable bits to 0, clears the hold-off and the wait-for-acknowledge state, and holds `start_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Interrupt request lines, line 0 highest priority |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NUM_SRC | New enable value, 1 allows a line |
| active_i | input | 1 | Core in-service status bit |
| ack_i | input | 1 | Core acknowledge of the last start |
| start_o | output | 1 | One-cycle interrupt start strobe |
| vec_o | output | IDX_W | Index of the started line, 0 when idle |
| clr_o | output | NUM_SRC | One-hot clear of the serviced pending bit |

## Verification
The bench builds two copies with eight lines.

- `u0` sets `TOP_NMI` = 1 and `SEQ_MODE` = 1. This copy exercises a masked line 0 still starting, the hold-off suppressing both a masked-then-enabled line and the non-maskable line, and the release one cycle after `active_i` falls.
- `u1` sets both options to 0. This copy exercises priority ordering across several simultaneous pulses, enable gating with accumulation, same-cycle re-requests, and starts while `active_i` is held high.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] en_o
);

  logic [NUM_SRC-1:0] pend_q, en_q;

  // new requests win over the clear of the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | req_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

  assert_req_capture_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(req_i)) == $past(req_i)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_SRC = 8,
  parameter bit          TOP_NMI = 1'b0,
  localparam int unsigned IDX_W  = irq_pend_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  localparam logic [NUM_SRC-1:0] NMI_MASK = TOP_NMI ? NUM_SRC'(1) : '0;

  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC:0]   lower_any;

  assign elig         = pend_i & (en_i | NMI_MASK);
  assign lower_any[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign lower_any[g+1] = lower_any[g] | elig[g];
    assign grant_o[g]     = elig[g] & ~lower_any[g];
  end

  assign any_o = lower_any[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(grant_o));
    assert_grant_eligible_R2: assert ((grant_o & ~(en_i | NMI_MASK)) == '0);
  end

endmodule

// File: rtl/irq_issue_ctl.sv
module irq_issue_ctl #(
  parameter bit SEQ_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  input  logic active_i,
  input  logic ack_i,
  output logic take_o
);

  logic wait_q, hold_q;

  assign take_o = any_i & ~wait_q & ~hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= SEQ_MODE & active_i;
      if (take_o)     wait_q <= 1'b1;
      else if (ack_i) wait_q <= 1'b0;
    end
  end

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_wait_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o || (wait_q && !ack_i)) |=> !take_o);

  assert_seq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SEQ_MODE && active_i) |=> !take_o);

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && any_i && !wait_q && !take_o && !ack_i) |=> (!any_i || take_o || $past(wait_q)));

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int unsigned NUM_SRC  = 8,
  parameter bit          TOP_NMI  = 1'b0,
  parameter bit          SEQ_MODE = 1'b0,
  localparam int unsigned IDX_W   = irq_pend_pkg::idx_width(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               en_we_i,
  input  logic [NUM_SRC-1:0] en_wdata_i,
  input  logic               active_i,
  input  logic               ack_i,
  output logic               start_o,
  output logic [IDX_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] clr_o
);

  logic [NUM_SRC-1:0] pend, en, grant;
  logic [IDX_W-1:0]   idx;
  logic               any, take;

  irq_pend_reg #(.NUM_SRC(NUM_SRC)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .clr_i      (clr_o),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .pend_o     (pend),
    .en_o       (en)
  );

  irq_prio_pick #(.NUM_SRC(NUM_SRC), .TOP_NMI(TOP_NMI)) u_pick (
    .pend_i  (pend),
    .en_i    (en),
    .grant_o (grant),
    .any_o   (any),
    .idx_o   (idx)
  );

  irq_issue_ctl #(.SEQ_MODE(SEQ_MODE)) u_issue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_i    (any),
    .active_i (active_i),
    .ack_i    (ack_i),
    .take_o   (take)
  );

  assign start_o = take;
  assign vec_o   = take ? idx : '0;
  assign clr_o   = take ? grant : '0;

  assert_vec_matches_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (clr_o[vec_o] && $onehot(clr_o)));

  assert_lower_not_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ((pend & (en | NUM_SRC'(TOP_NMI)) & ((clr_o - 1'b1) & ~clr_o)) == '0));

  assert_enable_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (en[vec_o] || (TOP_NMI && vec_o == '0)));

  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> (clr_o == '0 && vec_o == '0));

endmodule

// File: tb/sim_irq_pend_ctrl.sv
`timescale 1ns/1ps
module sim_irq_pend_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] req0 = '0, mdat0 = '0, req1 = '0, mdat1 = '0;
  logic mwe0 = 1'b0, act0 = 1'b0, ack0 = 1'b0;
  logic mwe1 = 1'b0, act1 = 1'b0, ack1 = 1'b0;
  logic st0, st1;
  logic [2:0] vec0, vec1;
  logic [7:0] clr0, clr1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irq_pend_ctrl #(.NUM_SRC(8), .TOP_NMI(1'b1), .SEQ_MODE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req0), .en_we_i(mwe0), .en_wdata_i(mdat0),
    .active_i(act0), .ack_i(ack0), .start_o(st0), .vec_o(vec0), .clr_o(clr0));

  irq_pend_ctrl #(.NUM_SRC(8), .TOP_NMI(1'b0), .SEQ_MODE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .en_we_i(mwe1), .en_wdata_i(mdat1),
    .active_i(act1), .ack_i(ack1), .start_o(st1), .vec_o(vec1), .clr_o(clr1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    cyc(); chk("R10 u0 start in reset", st0, 0); chk("R10 u1 start in reset", st1, 0);
    rst_n = 1'b1;
    cyc(); chk("R10 u1 idle after reset", st1, 0);
    mwe1 = 1'b1; mdat1 = 8'hff; req0 = 8'h02;
    cyc(); mwe1 = 1'b0; req0 = '0;
    chk("R10 u1 pending empty", st1, 0);
    chk("R10 u0 line1 masked after reset", st0, 0);
    cyc(); chk("R10 u0 still masked", st0, 0);
  endtask

  task automatic t_masked();
    cyc(); mwe1 = 1'b1; mdat1 = 8'h00;
    cyc(); mwe1 = 1'b0; req1 = 8'h20;
    cyc(); req1 = '0; chk("R2 masked line not started", st1, 0);
    cyc(); chk("R2 masked line held", st1, 0); mwe1 = 1'b1; mdat1 = 8'h20;
    cyc(); mwe1 = 1'b0;
    chk("R1 pulse remembered start", st1, 1); chk("R2 vec after enable", vec1, 5);
    chk("R3 clr one-hot", clr1, 8'h20);
    cyc(); chk("R4 single cycle start", st1, 0); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R1 cleared after service", st1, 0);
  endtask

  task automatic t_prio();
    cyc(); mwe1 = 1'b1; mdat1 = 8'hff; act1 = 1'b1;
    cyc(); mwe1 = 1'b0; req1 = 8'h94;
    cyc(); req1 = '0;
    chk("R9 start while active", st1, 1); chk("R3 lowest wins", vec1, 2);
    chk("R3 clr bit2", clr1, 8'h04);
    cyc(); chk("R4 no reissue before ack", st1, 0);
    cyc(); chk("R4 still waiting", st1, 0); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R4 start after ack", st1, 1); chk("R3 next line", vec1, 4);
    cyc(); chk("R4 pulse ends", st1, 0); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R3 last line start", st1, 1); chk("R3 last line vec", vec1, 7);
    cyc(); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R1 all serviced", st1, 0); act1 = 1'b0;
  endtask

  task automatic t_rereq();
    cyc(); req1 = 8'h08;
    cyc(); chk("R5 first start", st1, 1); chk("R5 first vec", vec1, 3);
    cyc(); req1 = '0; chk("R5 waiting", st1, 0); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R5 re-request kept", st1, 1); chk("R5 vec again", vec1, 3);
    cyc(); ack1 = 1'b1;
    cyc(); ack1 = 1'b0; chk("R5 drained", st1, 0);
  endtask

  task automatic t_nmi_seq();
    cyc(); req0 = 8'h01;
    cyc(); req0 = '0;
    chk("R6 masked line0 starts", st0, 1); chk("R6 vec0", vec0, 0); chk("R6 clr0", clr0, 8'h01);
    cyc(); chk("R4 u0 pulse ends", st0, 0); act0 = 1'b1; ack0 = 1'b1;
    cyc(); ack0 = 1'b0; chk("R7 held while active", st0, 0); mwe0 = 1'b1; mdat0 = 8'hff;
    cyc(); mwe0 = 1'b0; req0 = 8'h01; chk("R7 enabled line held", st0, 0);
    cyc(); req0 = '0; chk("R7 line0 held", st0, 0);
    cyc(); chk("R7 still held", st0, 0); act0 = 1'b0;
    cyc(); chk("R8 release start", st0, 1); chk("R8 release vec", vec0, 0);
    cyc(); chk("R4 u0 wait", st0, 0); act0 = 1'b1; ack0 = 1'b1;
    cyc(); ack0 = 1'b0; chk("R7 held again", st0, 0);
    cyc(); chk("R7 held before clear", st0, 0); act0 = 1'b0;
    cyc(); chk("R8 second release", st0, 1); chk("R8 second vec", vec0, 1);
    cyc(); ack0 = 1'b1;
    cyc(); ack0 = 1'b0; chk("R1 u0 drained", st0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_masked();
    t_prio();
    t_rereq();
    t_nmi_seq();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule